// File: doc/BRIEF.md
# Security-Filtered Performance Event Counters

This block is a small performance monitor holding one free-running cycle counter and a parameterised set of general event counters, all 64 bits wide. Each general counter watches one line of an event pulse vector, chosen by a 10-bit event number held in its type register. The cycle counter counts clock cycles. Each counter advances only when four conditions all hold: the run bit is set, its own enable bit is set, its privilege/security filter accepts the current exception level and security state, and no secure-side prohibition applies.

Software reaches the registers through a simple port. A write takes effect on the next clock edge. A read is combinational on the read address and returns the state registered at the last edge. Counters can be preset through the same port, and wrap silently past all ones. The exception level (0 to 3) and the secure flag come from the core each cycle. Level 3 always counts as secure.

Top module: `perfmon_top`

## Requirements
- R1: After reset, every register reads 0 and every counter output is 0.
- R2: With the run bit clear (bit 0 of the main control register, address 0), no counter increments, whatever the enable bits are.
- R3: In the enable-set register (address 1), bit n enables general counter n and bit 31 enables the cycle counter. A 1 written to a bit sets it, a 0 written leaves it unchanged, and enable bits never clear except by reset.
- R4: A general counter increments in a cycle only when the event pulse selected by bits 9:0 of its type register is high. Event number 0x00C (retired writes to the program counter) selects pulse 12. A number at or beyond the width of the pulse vector never counts.
- R5: Filter bit 31 blocks counting at level 1. At non-secure level 1 the counter counts only when bit 29 equals bit 31 and bit 31 is 0. At secure level 1, bit 29 has no effect. Bit 25 never affects counting.
- R6: Filter bit 30 blocks counting at level 0. At non-secure level 0 the counter counts only when bit 28 equals bit 30 and bit 30 is 0.
- R7: At non-secure level 2, counting requires filter bit 27 = 1. At secure level 2, counting requires bit 24 to differ from bit 27.
- R8: At level 3, counting requires filter bit 26 to equal bit 31. Level 3 is treated as secure even when the secure flag is low.
- R9: In secure state, general counters do not increment while the secure-event-allow bit (bit 0 of the secure control register, address 2) is 0.
- R10: The cycle counter obeys the R9 prohibition only while bit 5 of the main control register is 1. With that bit 0, it keeps counting in secure state.
- R11: The secure-cycle-block bit (bit 1 of the secure control register) stops the cycle counter in secure state, whatever the value of main control bit 5. It has no effect in non-secure state.
- R12: A write to a counter (cycle counter at address 4, general counter n at 16+n) replaces its value even when an increment falls in the same cycle. A counter at all ones wraps to 0 on its next increment.
- R13: The read port returns each register's stored value. The cycle filter (address 3) keeps bits 31:24. Type register n (address 8+n) keeps bits 31:24 and 9:0 and reads 0 in the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| el_i | input | 2 | Current exception level, 0 to 3 |
| secure_i | input | 1 | Current security state, 1 = secure |
| evt_pulse_i | input | EVT_VEC_W | Event pulses, one line per event number |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | CNT_W | Register read data |
| cyc_cnt_o | output | CNT_W | Cycle counter value |
| evt_cnt_o | output | NUM_EVT*CNT_W | General counter values, counter n at bits n*CNT_W upward |

## Verification
Some properties are checked on every cycle by the assertions. A counter holds its value unless it is written or qualified. A write beats an increment. The counter wraps from all ones to zero. Enable bits never fall. The run bit and the secure prohibitions freeze the counters. The per-level filter decode can only be shown by the bench's scenario table, which drives each exception level and security state against chosen filter patterns and prohibition settings. Event selection, out-of-range event numbers and register read masking are also covered only by the bench.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  // register map (word addresses)
  localparam int A_CTRL      = 0;
  localparam int A_ENSET     = 1;
  localparam int A_SECCTL    = 2;
  localparam int A_CYCFILT   = 3;
  localparam int A_CYCCNT    = 4;
  localparam int A_TYPE_BASE = 8;
  localparam int A_ECNT_BASE = 16;

  // bit positions inside the 32-bit register words
  localparam int CTRL_RUN      = 0;
  localparam int CTRL_CYC_HON  = 5;
  localparam int SEC_EVT_ALLOW = 0;
  localparam int SEC_CYC_BLOCK = 1;
  localparam int ENSET_CYC     = 31;
  localparam int FILT_LSB      = 24;

  // offsets inside the filter byte (word bits 31:24)
  localparam int F_K_EXCL   = 7;
  localparam int F_U_EXCL   = 6;
  localparam int F_NS_K_TOG = 5;
  localparam int F_NS_U_TOG = 4;
  localparam int F_NS_H_INC = 3;
  localparam int F_MON_EQ   = 2;
  localparam int F_S_H_TOG  = 0;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } exc_level_e;

  // privilege / security filter decode on the filter byte
  function automatic logic filt_allows(input logic [7:0] f, input logic [1:0] lvl,
                                       input logic sec);
    logic ok;
    case (lvl)
      LVL_USER:   ok = sec ? !f[F_U_EXCL]
                           : ((f[F_NS_U_TOG] == f[F_U_EXCL]) && !f[F_U_EXCL]);
      LVL_KERNEL: ok = sec ? !f[F_K_EXCL]
                           : ((f[F_NS_K_TOG] == f[F_K_EXCL]) && !f[F_K_EXCL]);
      LVL_HYP:    ok = sec ? (f[F_S_H_TOG] != f[F_NS_H_INC]) : f[F_NS_H_INC];
      default:    ok = (f[F_MON_EQ] == f[F_K_EXCL]);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/perfmon_regs.sv
module perfmon_regs
  import perfmon_pkg::*;
#(
  parameter int NUM_EVT   = 4,
  parameter int ADDR_W    = 6,
  parameter int EVT_NUM_W = 10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en_i,
  input  logic [ADDR_W-1:0]                    wr_addr_i,
  input  logic [31:0]                          wr_data_i,
  output logic                                 run_o,
  output logic                                 cyc_hon_o,
  output logic                                 sec_evt_allow_o,
  output logic                                 sec_cyc_block_o,
  output logic [NUM_EVT-1:0]                   cnt_en_o,
  output logic                                 cyc_en_o,
  output logic [7:0]                           cyc_filt_o,
  output logic [NUM_EVT-1:0][7:0]              type_filt_o,
  output logic [NUM_EVT-1:0][EVT_NUM_W-1:0]    type_evt_o
);

  localparam logic [ADDR_W-1:0] AD_CTRL    = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_ENSET   = ADDR_W'(A_ENSET);
  localparam logic [ADDR_W-1:0] AD_SECCTL  = ADDR_W'(A_SECCTL);
  localparam logic [ADDR_W-1:0] AD_CYCFILT = ADDR_W'(A_CYCFILT);

  logic unused_wdata;
  assign unused_wdata = ^wr_data_i[FILT_LSB-1:EVT_NUM_W];

  logic wr_ctrl, wr_enset, wr_secctl, wr_cycfilt;
  assign wr_ctrl    = wr_en_i && (wr_addr_i == AD_CTRL);
  assign wr_enset   = wr_en_i && (wr_addr_i == AD_ENSET);
  assign wr_secctl  = wr_en_i && (wr_addr_i == AD_SECCTL);
  assign wr_cycfilt = wr_en_i && (wr_addr_i == AD_CYCFILT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_o           <= 1'b0;
      cyc_hon_o       <= 1'b0;
      sec_evt_allow_o <= 1'b0;
      sec_cyc_block_o <= 1'b0;
      cnt_en_o        <= '0;
      cyc_en_o        <= 1'b0;
      cyc_filt_o      <= '0;
    end else begin
      if (wr_ctrl) begin
        run_o     <= wr_data_i[CTRL_RUN];
        cyc_hon_o <= wr_data_i[CTRL_CYC_HON];
      end
      if (wr_secctl) begin
        sec_evt_allow_o <= wr_data_i[SEC_EVT_ALLOW];
        sec_cyc_block_o <= wr_data_i[SEC_CYC_BLOCK];
      end
      if (wr_enset) begin
        cnt_en_o <= cnt_en_o | wr_data_i[NUM_EVT-1:0];
        cyc_en_o <= cyc_en_o | wr_data_i[ENSET_CYC];
      end
      if (wr_cycfilt) cyc_filt_o <= wr_data_i[31:FILT_LSB];
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_type
    logic wr_type;
    assign wr_type = wr_en_i && (wr_addr_i == ADDR_W'(A_TYPE_BASE + i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        type_filt_o[i] <= '0;
        type_evt_o[i]  <= '0;
      end else if (wr_type) begin
        type_filt_o[i] <= wr_data_i[31:FILT_LSB];
        type_evt_o[i]  <= wr_data_i[EVT_NUM_W-1:0];
      end
    end
  end

  // R3: enable-set bits are sticky
  p_enset_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_o & $past(cnt_en_o)) == $past(cnt_en_o));
  p_cyc_en_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_en_o) |-> cyc_en_o);

endmodule

// File: rtl/perfmon_gate.sv
module perfmon_gate
  import perfmon_pkg::*;
(
  input  logic       run_i,
  input  logic       ctr_en_i,
  input  logic [7:0] filt_i,
  input  logic [1:0] lvl_i,
  input  logic       sec_i,
  input  logic       prohib_i,
  input  logic       hit_i,
  output logic       inc_o,
  output logic       filt_ok_o
);

  assign filt_ok_o = filt_allows(filt_i, lvl_i, sec_i);
  assign inc_o     = run_i && ctr_en_i && filt_ok_o && !prohib_i && hit_i;

endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_o <= '0;
    else if (ld_i)  cnt_o <= ld_val_i;
    else if (inc_i) cnt_o <= bump(cnt_o);
  end

  // R12: software write wins over increment
  p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> cnt_o == $past(ld_val_i));
  // R12: silent wrap
  p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && (&cnt_o)) |=> cnt_o == '0);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !ld_i) |=> $stable(cnt_o));

endmodule

// File: rtl/perfmon_top.sv
module perfmon_top
  import perfmon_pkg::*;
#(
  parameter int NUM_EVT   = 4,
  parameter int CNT_W     = 64,
  parameter int EVT_VEC_W = 32,
  parameter int ADDR_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               el_i,
  input  logic                     secure_i,
  input  logic [EVT_VEC_W-1:0]     evt_pulse_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [CNT_W-1:0]         wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [CNT_W-1:0]         rd_data_o,
  output logic [CNT_W-1:0]         cyc_cnt_o,
  output logic [NUM_EVT*CNT_W-1:0] evt_cnt_o
);

  localparam int EVT_NUM_W = 10;
  localparam int SEL_W     = (EVT_VEC_W > 1) ? $clog2(EVT_VEC_W) : 1;
  localparam logic [ADDR_W-1:0] AD_CTRL    = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_ENSET   = ADDR_W'(A_ENSET);
  localparam logic [ADDR_W-1:0] AD_SECCTL  = ADDR_W'(A_SECCTL);
  localparam logic [ADDR_W-1:0] AD_CYCFILT = ADDR_W'(A_CYCFILT);
  localparam logic [ADDR_W-1:0] AD_CYCCNT  = ADDR_W'(A_CYCCNT);

  // register state
  logic                              run, cyc_hon, sec_evt_allow, sec_cyc_block;
  logic [NUM_EVT-1:0]                cnt_en;
  logic                              cyc_en;
  logic [7:0]                        cyc_filt;
  logic [NUM_EVT-1:0][7:0]           type_filt;
  logic [NUM_EVT-1:0][EVT_NUM_W-1:0] type_evt;

  perfmon_regs #(
    .NUM_EVT  (NUM_EVT),
    .ADDR_W   (ADDR_W),
    .EVT_NUM_W(EVT_NUM_W)
  ) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en_i        (wr_en_i),
    .wr_addr_i      (wr_addr_i),
    .wr_data_i      (wr_data_i[31:0]),
    .run_o          (run),
    .cyc_hon_o      (cyc_hon),
    .sec_evt_allow_o(sec_evt_allow),
    .sec_cyc_block_o(sec_cyc_block),
    .cnt_en_o       (cnt_en),
    .cyc_en_o       (cyc_en),
    .cyc_filt_o     (cyc_filt),
    .type_filt_o    (type_filt),
    .type_evt_o     (type_evt)
  );

  // named internal events for the assertions
  logic sec_eff;          // level 3 is always secure
  logic evt_prohib;       // secure prohibition on general counters
  logic cyc_prohib;       // secure prohibition on the cycle counter
  logic ld_cyc;
  logic cyc_inc, cyc_filt_ok;
  logic [CNT_W-1:0] cyc_cnt;

  assign sec_eff    = secure_i || (el_i == LVL_MON);
  assign evt_prohib = sec_eff && !sec_evt_allow;
  assign cyc_prohib = sec_eff && ((cyc_hon && !sec_evt_allow) || sec_cyc_block);
  assign ld_cyc     = wr_en_i && (wr_addr_i == AD_CYCCNT);

  perfmon_gate u_cyc_gate (
    .run_i    (run),
    .ctr_en_i (cyc_en),
    .filt_i   (cyc_filt),
    .lvl_i    (el_i),
    .sec_i    (sec_eff),
    .prohib_i (cyc_prohib),
    .hit_i    (1'b1),
    .inc_o    (cyc_inc),
    .filt_ok_o(cyc_filt_ok)
  );

  perfmon_counter #(.CNT_W(CNT_W)) u_cyc_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (cyc_inc),
    .ld_i    (ld_cyc),
    .ld_val_i(wr_data_i),
    .cnt_o   (cyc_cnt)
  );
  assign cyc_cnt_o = cyc_cnt;

  logic [NUM_EVT-1:0] ld_evt, evt_inc, evt_hit, evt_filt_ok;
  logic [CNT_W-1:0]   evt_cnt [NUM_EVT];

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign ld_evt[i]  = wr_en_i && (wr_addr_i == ADDR_W'(A_ECNT_BASE + i));
    assign evt_hit[i] = (32'(type_evt[i]) < 32'(EVT_VEC_W))
                        ? evt_pulse_i[type_evt[i][SEL_W-1:0]] : 1'b0;

    perfmon_gate u_gate (
      .run_i    (run),
      .ctr_en_i (cnt_en[i]),
      .filt_i   (type_filt[i]),
      .lvl_i    (el_i),
      .sec_i    (sec_eff),
      .prohib_i (evt_prohib),
      .hit_i    (evt_hit[i]),
      .inc_o    (evt_inc[i]),
      .filt_ok_o(evt_filt_ok[i])
    );

    perfmon_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (evt_inc[i]),
      .ld_i    (ld_evt[i]),
      .ld_val_i(wr_data_i),
      .cnt_o   (evt_cnt[i])
    );
    assign evt_cnt_o[i*CNT_W +: CNT_W] = evt_cnt[i];

    // R9: secure state without permission freezes general counters
    p_sec_evt_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_eff && !sec_evt_allow && !ld_evt[i]) |=> $stable(evt_cnt[i]));
    // R2: run bit low freezes general counters
    p_run_off_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_evt[i]) |=> $stable(evt_cnt[i]));
    // R5: a rejected filter never advances the counter
    p_filt_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_filt_ok[i] && !ld_evt[i]) |=> $stable(evt_cnt[i]));
  end

  // R2: run bit low freezes the cycle counter
  p_run_off_cyc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_cyc) |=> $stable(cyc_cnt));
  // R11: secure cycle block freezes the cycle counter
  p_sec_cyc_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_eff && sec_cyc_block && !ld_cyc) |=> $stable(cyc_cnt));
  // R10: honoured prohibition freezes the cycle counter
  p_cyc_honour_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_eff && cyc_hon && !sec_evt_allow && !ld_cyc) |=> $stable(cyc_cnt));
  p_cyc_filt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_filt_ok && !ld_cyc) |=> $stable(cyc_cnt));

  // R13: read mux over registered state
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AD_CTRL) begin
      rd_data_o[CTRL_RUN]     = run;
      rd_data_o[CTRL_CYC_HON] = cyc_hon;
    end else if (rd_addr_i == AD_ENSET) begin
      rd_data_o[NUM_EVT-1:0]  = cnt_en;
      rd_data_o[ENSET_CYC]    = cyc_en;
    end else if (rd_addr_i == AD_SECCTL) begin
      rd_data_o[SEC_EVT_ALLOW] = sec_evt_allow;
      rd_data_o[SEC_CYC_BLOCK] = sec_cyc_block;
    end else if (rd_addr_i == AD_CYCFILT) begin
      rd_data_o[31:FILT_LSB]  = cyc_filt;
    end else if (rd_addr_i == AD_CYCCNT) begin
      rd_data_o = cyc_cnt;
    end
    for (int i = 0; i < NUM_EVT; i++) begin
      if (rd_addr_i == ADDR_W'(A_TYPE_BASE + i)) begin
        rd_data_o[31:FILT_LSB]    = type_filt[i];
        rd_data_o[EVT_NUM_W-1:0]  = type_evt[i];
      end
      if (rd_addr_i == ADDR_W'(A_ECNT_BASE + i)) rd_data_o = evt_cnt[i];
    end
  end

endmodule

// File: tb/perfmon_top_tb.sv
`timescale 1ns/1ps
module perfmon_top_tb;

  localparam int NE = 4;
  localparam int CW = 64;
  localparam int VW = 32;
  localparam int AW = 6;

  localparam logic [AW-1:0] R_CTRL = 6'd0, R_ENSET = 6'd1, R_SEC = 6'd2,
                            R_CYCF = 6'd3, R_CYCC = 6'd4, R_TYP0 = 6'd8,
                            R_TYP1 = 6'd9, R_EC0 = 6'd16, R_EC1 = 6'd17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] el = 2'd1;
  logic sec = 1'b0;
  logic [VW-1:0] evt = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data, cyc;
  logic [NE*CW-1:0] ecnt;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  perfmon_top #(.NUM_EVT(NE), .CNT_W(CW), .EVT_VEC_W(VW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .el_i(el), .secure_i(sec), .evt_pulse_i(evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cyc_cnt_o(cyc), .evt_cnt_o(ecnt)
  );

  // vector: el[15:14] sec[13] filt[12:5] blk[4] allow[3] hon[2] ecyc[1] eevt[0]
  localparam int NV = 24;
  localparam logic [15:0] VT [NV] = '{
    {2'd1, 1'b0, 8'h00, 3'b000, 2'b11},
    {2'd1, 1'b0, 8'h80, 3'b000, 2'b00},
    {2'd1, 1'b0, 8'hA0, 3'b000, 2'b00},
    {2'd1, 1'b0, 8'h20, 3'b000, 2'b00},
    {2'd1, 1'b1, 8'h20, 3'b010, 2'b11},
    {2'd1, 1'b1, 8'h80, 3'b010, 2'b00},
    {2'd0, 1'b0, 8'h00, 3'b000, 2'b11},
    {2'd0, 1'b0, 8'h10, 3'b000, 2'b00},
    {2'd0, 1'b1, 8'h40, 3'b010, 2'b00},
    {2'd0, 1'b1, 8'h10, 3'b010, 2'b11},
    {2'd2, 1'b0, 8'h00, 3'b000, 2'b00},
    {2'd2, 1'b0, 8'h08, 3'b000, 2'b11},
    {2'd2, 1'b1, 8'h01, 3'b010, 2'b11},
    {2'd2, 1'b1, 8'h09, 3'b010, 2'b00},
    {2'd3, 1'b1, 8'h00, 3'b010, 2'b11},
    {2'd3, 1'b1, 8'h04, 3'b010, 2'b00},
    {2'd3, 1'b1, 8'h84, 3'b010, 2'b11},
    {2'd3, 1'b1, 8'h00, 3'b000, 2'b10},
    {2'd3, 1'b1, 8'h00, 3'b001, 2'b00},
    {2'd1, 1'b1, 8'h00, 3'b110, 2'b01},
    {2'd1, 1'b0, 8'h00, 3'b101, 2'b11},
    {2'd1, 1'b1, 8'h00, 3'b000, 2'b10},
    {2'd1, 1'b0, 8'h02, 3'b000, 2'b11},
    {2'd3, 1'b0, 8'h00, 3'b001, 2'b00}
  };

  task automatic check(input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [CW-1:0] exp);
    rd_addr = a;
    #1;
    check(req, "read", rd_data, exp);
  endtask

  function automatic string lvl_tag(input logic [1:0] l);
    case (l)
      2'd0: return "R6";
      2'd1: return "R5";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [CW-1:0] c0, e0, e1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1", "cycle counter", cyc, '0);
    check("R1", "event counters", ecnt[CW-1:0], '0);
    rd_chk("R1", R_CTRL, '0);
    rd_chk("R1", R_ENSET, '0);
    rd_chk("R1", R_SEC, '0);
    rd_chk("R1", R_TYP0, '0);

    wr(R_ENSET, 64'h8000_0001);

    // scenario table: filters and prohibitions
    for (int v = 0; v < NV; v++) begin
      logic [15:0] t;
      string tc, te;
      t = VT[v];
      el = t[15:14]; sec = t[13]; evt = 32'h0000_1000;  // pulse 12 = event 0x00C (R4)
      wr(R_CTRL, {58'd0, t[2], 4'd0, 1'b1});
      wr(R_SEC, {62'd0, t[4], t[3]});
      wr(R_CYCF, {32'd0, t[12:5], 24'd0});
      wr(R_TYP0, {32'd0, t[12:5], 24'd0} | 64'h00C);
      c0 = cyc; e0 = ecnt[CW-1:0];
      repeat (4) @(posedge clk);
      @(negedge clk);
      tc = (t[13] || t[15:14] == 2'd3) && t[4] ? "R11"
         : ((t[13] || t[15:14] == 2'd3) && !t[3] ? "R10" : lvl_tag(t[15:14]));
      te = ((t[13] || t[15:14] == 2'd3) && !t[3]) ? "R9" : lvl_tag(t[15:14]);
      check(tc, $sformatf("vec %0d cycle delta", v), cyc - c0, t[1] ? 64'd4 : 64'd0);
      check(te, $sformatf("vec %0d event delta", v), ecnt[CW-1:0] - e0, t[0] ? 64'd4 : 64'd0);
    end

    // back to a plain counting setup
    el = 2'd1; sec = 1'b0;
    wr(R_SEC, 64'd0);
    wr(R_CYCF, 64'd0);
    wr(R_TYP0, 64'h00C);

    // R2: run bit clear
    wr(R_CTRL, 64'h0);
    c0 = cyc; e0 = ecnt[CW-1:0];
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2", "cycle delta run off", cyc - c0, 64'd0);
    check("R2", "event delta run off", ecnt[CW-1:0] - e0, 64'd0);
    wr(R_CTRL, 64'h1);

    // R3: writing 0 keeps enables, unenabled counter idle, set adds
    wr(R_ENSET, 64'h0);
    rd_chk("R3", R_ENSET, 64'h8000_0001);
    wr(R_TYP1, 64'h00C);
    e1 = ecnt[2*CW-1:CW];
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R3", "disabled counter 1 delta", ecnt[2*CW-1:CW] - e1, 64'd0);
    wr(R_ENSET, 64'h2);
    rd_chk("R3", R_ENSET, 64'h8000_0003);
    e1 = ecnt[2*CW-1:CW];
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R3", "enabled counter 1 delta", ecnt[2*CW-1:CW] - e1, 64'd4);

    // R4: event selection follows pulse line 5 only
    wr(R_TYP1, 64'h005);
    evt = '0;
    e0 = ecnt[CW-1:0]; e1 = ecnt[2*CW-1:CW];
    for (int k = 0; k < 4; k++) begin
      evt[5] = (k % 2 == 0);
      @(posedge clk);
      @(negedge clk);
    end
    check("R4", "counter 1 on alternating pulse", ecnt[2*CW-1:CW] - e1, 64'd2);
    check("R4", "counter 0 with pulse 12 low", ecnt[CW-1:0] - e0, 64'd0);
    wr(R_TYP1, 64'h3FF);
    evt = '1;
    e0 = ecnt[CW-1:0]; e1 = ecnt[2*CW-1:CW];
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R4", "out-of-range event number", ecnt[2*CW-1:CW] - e1, 64'd0);
    check("R4", "event 0x00C all pulses", ecnt[CW-1:0] - e0, 64'd4);

    // R12: write wins over increment, then wrap
    wr(R_EC0, 64'd100);
    check("R12", "write over increment", ecnt[CW-1:0], 64'd100);
    wr(R_EC0, '1);
    check("R12", "preset all ones", ecnt[CW-1:0], '1);
    @(posedge clk);
    @(negedge clk);
    check("R12", "wrap to zero", ecnt[CW-1:0], 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R12", "count after wrap", ecnt[CW-1:0], 64'd1);

    // R13: read port and field masks
    wr(R_CTRL, 64'h20);
    wr(R_CYCC, 64'h1234_5678_9ABC_DEF0);
    rd_chk("R13", R_CYCC, 64'h1234_5678_9ABC_DEF0);
    rd_chk("R13", R_CTRL, 64'h20);
    wr(R_TYP1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R13", R_TYP1, 64'h0000_0000_FF00_03FF);
    wr(R_CYCF, 64'hFFFF_FFFF);
    rd_chk("R13", R_CYCF, 64'hFF00_0000);
    wr(R_SEC, 64'h3);
    rd_chk("R13", R_SEC, 64'h3);
    wr(R_EC1, 64'hDEAD);
    rd_chk("R13", R_EC1, 64'hDEAD);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule